// File: doc/BRIEF.md
# Configurable USART Framing Core

This block is a serial transmitter and receiver pair whose framing is fixed by static mode inputs. It frames and recovers characters of 5 to 8 bits, or 9 bits when a forced nine-bit input is set. It sends either end of the character first and closes each frame with one, one and a half or two stop bits. Bit timing comes from a baud tick input that pulses once per receive sample. A bit lasts 16 ticks or 8 ticks, as the oversampling select chooses.

A channel-mode selector routes the two pins and the internal transmitter and receiver. Normal operation connects each side to its own pin. Automatic echo copies the input pin to the output pin while the receiver also listens. Local loopback feeds the transmitter straight into the receiver and holds the output pin idle. Remote loopback ties the input pin to the output pin and keeps the receiver idle.

Software-facing logic sits outside the block. The transmit side accepts a character when its ready flag is high. The receive side holds the last character with a ready flag until it is acknowledged.

Top module: `uart_frame_core`

## Requirements
- R1: A bit lasts 16 baud ticks when `ovs_sel` is 0 and 8 baud ticks when it is 1, on both transmit and receive.
- R2: With `nine_bit` clear, a character has 5, 6, 7 or 8 data bits for `char_len` 00, 01, 10, 11. With `nine_bit` set, it has 9 data bits whatever `char_len` holds.
- R3: With `msb_first` at 0 the least significant data bit is on the line first; with 1 the most significant bit is first. This holds for both directions.
- R4: With `sync_mode` at 0, `stop_sel` 00 gives one stop bit, 01 gives one and a half, 10 gives two and 11 gives one. The frame length from start bit to the return of `tx_ready` is (1 + bits) bit times plus the stop time, counted in baud ticks.
- R5: With `sync_mode` at 1, `stop_sel` 10 gives two stop bits and every other code gives one.
- R6: With `chan_mode` 00 the transmitter drives `txd`, the receiver listens to `rxd`, and `txd` is 1 while the transmitter is idle.
- R7: With `chan_mode` 01, `txd` follows `rxd` at once, the receiver still decodes `rxd`, and transmitted frames do not reach `txd`.
- R8: With `chan_mode` 10, the receiver decodes the transmitter's own frames, `txd` stays at 1 and `rxd` is ignored.
- R9: With `chan_mode` 11, `txd` follows `rxd` at once, transmitted frames do not reach `txd`, and the receiver reports no character.
- R10: A `tx_wr` pulse while `tx_ready` is 1 loads `tx_data`. `tx_ready` drops on the next cycle, the start bit (0) is driven from that cycle, and `tx_ready` stays low until the stop time has elapsed.
- R11: At the end of a received frame `rx_data` holds the character, zero-extended to 9 bits, and `rx_ready` rises. A `rx_ack` pulse clears `rx_ready` on the next cycle.
- R12: A low level on the receive input that ends before half a bit time is rejected as a start bit and yields no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle strobe, one per receive sample period |
| sync_mode | input | 1 | Selects the synchronous stop-bit code table |
| ovs_sel | input | 1 | 0: 16 ticks per bit, 1: 8 ticks per bit |
| nine_bit | input | 1 | Forces 9-bit characters |
| char_len | input | 2 | Character length, 5 + value bits |
| msb_first | input | 1 | Bit order select |
| stop_sel | input | 2 | Stop-bit code |
| chan_mode | input | 2 | Pin routing: normal, echo, local loop, remote loop |
| txd | output | 1 | Serial output pin |
| rxd | input | 1 | Serial input pin |
| tx_data | input | 9 | Character to transmit |
| tx_wr | input | 1 | Load strobe for `tx_data` |
| tx_ready | output | 1 | Transmitter can accept a character |
| rx_data | output | 9 | Last received character |
| rx_ready | output | 1 | A received character is waiting |
| rx_ack | input | 1 | Clears `rx_ready` |

## Verification
The assertions assume that the mode inputs stay fixed while a frame is in progress. They also assume that `tx_wr` and `rx_ack` are single-cycle strobes driven away from the clock edge. The bench changes configuration only while both directions are idle and `rx_ready` is clear. It drives every strobe and `rxd` level at the falling clock edge. It drives `rxd` frames with exact bit times of two clocks per tick, so the receiver sees clean edges that are aligned to ticks.

// File: rtl/ufc_pkg.sv
package ufc_pkg;
  localparam int DATA_W     = 9;
  localparam int OSR_WIDE   = 16;
  localparam int OSR_NARROW = 8;
  localparam int CNT_W      = $clog2(2 * OSR_WIDE + 1);
  localparam int IDX_W      = $clog2(DATA_W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} fsm_e;

  // ticks in one bit time
  function automatic logic [CNT_W-1:0] bit_ticks(input logic ovs);
    return ovs ? CNT_W'(OSR_NARROW) : CNT_W'(OSR_WIDE);
  endfunction

  // data bits per character
  function automatic logic [IDX_W-1:0] char_bits(input logic nine, input logic [1:0] len);
    return nine ? IDX_W'(DATA_W) : IDX_W'(5) + IDX_W'(len);
  endfunction

  // stop time in ticks; reserved codes fall back to one bit
  function automatic logic [CNT_W-1:0] stop_ticks(input logic sync, input logic [1:0] code,
                                                  input logic [CNT_W-1:0] bt);
    logic [CNT_W-1:0] r;
    r = bt;
    if (code == 2'b10) r = bt << 1;
    else if (code == 2'b01 && !sync) r = bt + (bt >> 1);
    return r;
  endfunction

  // data-word position of the idx-th bit on the line
  function automatic logic [IDX_W-1:0] bit_slot(input logic [IDX_W-1:0] idx,
                                                input logic [IDX_W-1:0] nb, input logic msb);
    return msb ? (nb - IDX_W'(1) - idx) : idx;
  endfunction
endpackage

// File: rtl/ufc_route.sv
module ufc_route (
  input  logic [1:0] chan_mode,
  input  logic       rxd,
  input  logic       tx_line,
  output logic       txd,
  output logic       rx_line
);
  always_comb begin
    case (chan_mode)
      2'b01:   begin txd = rxd;     rx_line = rxd;     end
      2'b10:   begin txd = 1'b1;    rx_line = tx_line; end
      2'b11:   begin txd = rxd;     rx_line = 1'b1;    end
      default: begin txd = tx_line; rx_line = rxd;     end
    endcase
  end
endmodule

// File: rtl/ufc_tx.sv
module ufc_tx import ufc_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CNT_W-1:0]  bt,
  input  logic [CNT_W-1:0]  st,
  input  logic [IDX_W-1:0]  nb,
  input  logic              msb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  output logic              ready,
  output logic              line
);
  fsm_e              state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              bit_end, stop_end;

  assign bit_end  = tick && (cnt == bt - CNT_W'(1));
  assign stop_end = tick && (cnt == st - CNT_W'(1));
  assign ready    = (state == ST_IDLE);

  always_comb begin
    case (state)
      ST_START: line = 1'b0;
      ST_DATA:  line = shreg[bit_slot(idx, nb, msb)];
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
    end else begin
      case (state)
        ST_IDLE: if (wr) begin
          shreg <= wdata;
          cnt   <= '0;
          idx   <= '0;
          state <= ST_START;
        end
        ST_START: if (bit_end) begin
          cnt   <= '0;
          state <= ST_DATA;
        end else if (tick) cnt <= cnt + CNT_W'(1);
        ST_DATA: if (bit_end) begin
          cnt <= '0;
          if (idx == nb - IDX_W'(1)) state <= ST_STOP;
          else idx <= idx + IDX_W'(1);
        end else if (tick) cnt <= cnt + CNT_W'(1);
        default: if (stop_end) begin
          cnt   <= '0;
          state <= ST_IDLE;
        end else if (tick) cnt <= cnt + CNT_W'(1);
      endcase
    end
  end
endmodule

// File: rtl/ufc_rx.sv
module ufc_rx import ufc_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CNT_W-1:0]  bt,
  input  logic [IDX_W-1:0]  nb,
  input  logic              msb,
  input  logic              line,
  input  logic              ack,
  output logic [DATA_W-1:0] data,
  output logic              ready,
  output logic              frame_end
);
  fsm_e                   state;
  logic [CNT_W-1:0]       cnt;
  logic [IDX_W-1:0]       idx;
  logic [DATA_W-1:0]      acc;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   smp, last_s, bit_mid, half_mid;

  assign smp       = sync_q[SYNC_STAGES-1];
  assign bit_mid   = tick && (cnt == bt - CNT_W'(1));
  assign half_mid  = tick && (cnt == (bt >> 1) - CNT_W'(1));
  assign frame_end = (state == ST_STOP) && bit_mid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      idx    <= '0;
      acc    <= '0;
      last_s <= 1'b1;
      data   <= '0;
      ready  <= 1'b0;
    end else begin
      if (frame_end) begin
        data  <= acc;
        ready <= 1'b1;
      end else if (ack) ready <= 1'b0;
      if (tick) last_s <= smp;
      case (state)
        ST_IDLE: if (tick && last_s && !smp) begin
          cnt   <= '0;
          acc   <= '0;
          state <= ST_START;
        end
        ST_START: if (half_mid) begin
          cnt   <= '0;
          idx   <= '0;
          state <= smp ? ST_IDLE : ST_DATA;
        end else if (tick) cnt <= cnt + CNT_W'(1);
        ST_DATA: if (bit_mid) begin
          cnt <= '0;
          acc[bit_slot(idx, nb, msb)] <= smp;
          if (idx == nb - IDX_W'(1)) state <= ST_STOP;
          else idx <= idx + IDX_W'(1);
        end else if (tick) cnt <= cnt + CNT_W'(1);
        default: if (bit_mid) begin
          cnt   <= '0;
          state <= ST_IDLE;
        end else if (tick) cnt <= cnt + CNT_W'(1);
      endcase
    end
  end
endmodule

// File: rtl/uart_frame_core.sv
module uart_frame_core import ufc_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              sync_mode,
  input  logic              ovs_sel,
  input  logic              nine_bit,
  input  logic [1:0]        char_len,
  input  logic              msb_first,
  input  logic [1:0]        stop_sel,
  input  logic [1:0]        chan_mode,
  output logic              txd,
  input  logic              rxd,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_wr,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              rx_ack
);
  logic [CNT_W-1:0] bt, st;
  logic [IDX_W-1:0] nb;
  logic             tx_line, rx_line, rx_frame_end;

  assign bt = bit_ticks(ovs_sel);
  assign nb = char_bits(nine_bit, char_len);
  assign st = stop_ticks(sync_mode, stop_sel, bt);

  ufc_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .bt(bt), .st(st), .nb(nb),
    .msb(msb_first), .wdata(tx_data), .wr(tx_wr), .ready(tx_ready), .line(tx_line)
  );

  ufc_route u_route (
    .chan_mode(chan_mode), .rxd(rxd), .tx_line(tx_line), .txd(txd), .rx_line(rx_line)
  );

  ufc_rx #(.SYNC_STAGES(2)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .bt(bt), .nb(nb), .msb(msb_first),
    .line(rx_line), .ack(rx_ack), .data(rx_data), .ready(rx_ready), .frame_end(rx_frame_end)
  );
endmodule

// File: rtl/ufc_chk.sv
module ufc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_wr,
  input logic       tx_ready,
  input logic       tx_line,
  input logic       rx_ack,
  input logic       rx_ready,
  input logic       rx_frame_end,
  input logic [1:0] chan_mode,
  input logic       txd,
  input logic       rxd
);
  // R10
  tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && tx_wr) |=> !tx_ready);
  // R10
  tx_start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> !tx_line);
  // R11
  rx_ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(rx_frame_end));
  // R11
  rx_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack && !rx_frame_end) |=> !rx_ready);
  // R8
  local_loop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_mode == 2'b10) |-> txd);
  // R7 R9
  pin_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_mode[0] |-> (txd == rxd));
  // R6
  tx_idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_mode == 2'b00 && tx_ready) |-> txd);
endmodule

bind uart_frame_core ufc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_ready(tx_ready), .tx_line(tx_line),
  .rx_ack(rx_ack), .rx_ready(rx_ready), .rx_frame_end(rx_frame_end),
  .chan_mode(chan_mode), .txd(txd), .rxd(rxd)
);

// File: tb/sim_uart_frame_core.sv
`timescale 1ns/1ps
module sim_uart_frame_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_div;
  logic sync_mode = 0, ovs_sel = 0, nine_bit = 0, msb_first = 0;
  logic [1:0] char_len = 0, stop_sel = 0, chan_mode = 0;
  logic rxd = 1'b1, tx_wr = 1'b0, rx_ack = 1'b0;
  logic [8:0] tx_data = '0;
  wire txd, tx_ready, rx_ready;
  wire [8:0] rx_data;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) tick_div <= 1'b0; else tick_div <= ~tick_div;

  uart_frame_core u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(tick_div), .sync_mode(sync_mode), .ovs_sel(ovs_sel),
    .nine_bit(nine_bit), .char_len(char_len), .msb_first(msb_first), .stop_sel(stop_sel),
    .chan_mode(chan_mode), .txd(txd), .rxd(rxd), .tx_data(tx_data), .tx_wr(tx_wr),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_ready(rx_ready), .rx_ack(rx_ack)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int osr_now();
    return ovs_sel ? 8 : 16;
  endfunction
  function automatic int nb_now();
    return nine_bit ? 9 : 5 + int'(char_len);
  endfunction
  function automatic int stop_halves();
    if (stop_sel == 2'b10) return 4;
    if (stop_sel == 2'b01 && !sync_mode) return 3;
    return 2;
  endfunction

  // transmit one character, decode txd at bit centres, time the frame
  task automatic do_tx(input logic [8:0] v, output logic [8:0] got, output bit start_ok,
                       output bit stop_ok, output int clks, output bit saw_low);
    int osr, nb;
    osr = osr_now(); nb = nb_now();
    got = '0; start_ok = 0; stop_ok = 0; clks = -1; saw_low = 0;
    @(negedge clk); tx_data = v; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
    chk(!tx_ready, "R10 ready low after write", tx_ready, 0);
    if (!txd) saw_low = 1;
    for (int c = 1; c < 4000; c++) begin
      @(negedge clk);
      if (tx_ready) begin clks = c; break; end
      if (!txd) saw_low = 1;
      if (c >= osr && (c - osr) % (2 * osr) == 0) begin
        int k;
        k = (c - osr) / (2 * osr);
        if (k == 0) start_ok = !txd;
        else if (k <= nb) got[msb_first ? nb - k : k - 1] = txd;
        else if (k == nb + 1) stop_ok = txd;
      end
    end
  endtask

  task automatic drive_frame(input logic [8:0] v, input int nb, input bit msb);
    int bc;
    bc = 2 * osr_now();
    @(negedge clk); rxd = 1'b0;
    repeat (bc - 1) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = v[msb ? nb - 1 - i : i];
      repeat (bc) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (2 * bc) @(negedge clk);
  endtask

  task automatic do_ack();
    @(negedge clk); rx_ack = 1'b1;
    @(negedge clk); rx_ack = 1'b0;
    chk(!rx_ready, "R11 ack clears ready", rx_ready, 0);
  endtask

  initial begin
    logic [8:0] got, v;
    bit s_ok, p_ok, low;
    int clks, tt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_ready, "R10 reset tx_ready", tx_ready, 1);
    chk(!rx_ready, "R11 reset rx_ready", rx_ready, 0);
    chk(txd, "R6 reset txd idle", txd, 1);

    // sweep: oversampling x length x order x async stop code, normal mode
    for (int o = 0; o < 2; o++)
      for (int L = 0; L < 5; L++)
        for (int m = 0; m < 2; m++)
          for (int s = 0; s < 4; s++) begin
            int nb;
            ovs_sel = o[0]; nine_bit = (L == 4); char_len = (L == 4) ? 2'b01 : L[1:0];
            msb_first = m[0]; stop_sel = s[1:0]; sync_mode = 0; chan_mode = 2'b00;
            nb = nb_now();
            v = 9'((37 * (o * 40 + L * 8 + m * 4 + s) + 149) & ((1 << nb) - 1));
            do_tx(v, got, s_ok, p_ok, clks, low);
            chk(got == v, "R2 R3 R6 tx data bits", got, v);
            chk(s_ok && p_ok, "R6 tx start/stop levels", {s_ok, p_ok}, 3);
            tt = osr_now() * (1 + nb) + stop_halves() * osr_now() / 2;
            chk(clks >= 2 * tt - 1 && clks <= 2 * tt + 1, "R1 R4 tx frame length", clks, 2 * tt);
            drive_frame(v, nb, msb_first);
            chk(rx_ready, "R11 rx ready after frame", rx_ready, 1);
            chk(rx_data == v, "R1 R2 R3 rx data", rx_data, v);
            do_ack();
          end

    // synchronous stop-code table
    sync_mode = 1; ovs_sel = 1; nine_bit = 0; char_len = 2'b11; msb_first = 0;
    for (int s = 0; s < 4; s++) begin
      stop_sel = s[1:0];
      do_tx(9'h0C3, got, s_ok, p_ok, clks, low);
      tt = 8 * 9 + stop_halves() * 4;
      chk(clks >= 2 * tt - 1 && clks <= 2 * tt + 1, "R5 sync stop length", clks, 2 * tt);
    end
    sync_mode = 0; stop_sel = 2'b00;

    // local loopback
    chan_mode = 2'b10;
    for (int k = 0; k < 3; k++) begin
      ovs_sel = k[0]; msb_first = k[1]; char_len = 2'(k + 1);
      v = 9'((91 * k + 45) & ((1 << nb_now()) - 1));
      rxd = 1'b0;
      do_tx(v, got, s_ok, p_ok, clks, low);
      rxd = 1'b1;
      chk(!low, "R8 txd held high", low, 0);
      repeat (4) @(negedge clk);
      chk(rx_ready && rx_data == v, "R8 rx gets own frame", rx_data, v);
      do_ack();
    end

    // automatic echo
    chan_mode = 2'b01; ovs_sel = 1; char_len = 2'b11; msb_first = 0;
    @(negedge clk); rxd = 1'b0; #1;
    chk(txd == 1'b0, "R7 echo low", txd, 0);
    rxd = 1'b1; #1;
    chk(txd == 1'b1, "R7 echo high", txd, 1);
    drive_frame(9'h05A, 8, 1'b0);
    chk(rx_ready && rx_data == 9'h05A, "R7 rx still decodes", rx_data, 9'h05A);
    do_ack();
    do_tx(9'h000, got, s_ok, p_ok, clks, low);
    chk(!low, "R7 tx frame kept off txd", low, 0);

    // remote loopback
    chan_mode = 2'b11;
    @(negedge clk); rxd = 1'b0; #1;
    chk(txd == 1'b0, "R9 remote low", txd, 0);
    rxd = 1'b1; #1;
    chk(txd == 1'b1, "R9 remote high", txd, 1);
    drive_frame(9'h033, 8, 1'b0);
    chk(!rx_ready, "R9 receiver isolated", rx_ready, 0);
    do_tx(9'h000, got, s_ok, p_ok, clks, low);
    chk(!low, "R9 tx frame kept off txd", low, 0);

    // short glitch rejection, then a good frame
    chan_mode = 2'b00; ovs_sel = 0;
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (80) @(negedge clk);
    chk(!rx_ready, "R12 glitch rejected", rx_ready, 0);
    drive_frame(9'h0A5, 8, 1'b0);
    chk(rx_ready && rx_data == 9'h0A5, "R12 recovers after glitch", rx_data, 9'h0A5);
    do_ack();

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule